// File: doc/BRIEF.md
# Byte-Addressed Memory Target on a Two-Wire Serial Bus

This block is an I2C target that fronts a small byte-wide register array. The controller opens every transfer with a START and a 7-bit device address followed by a direction bit. In the write direction it sends a word address and, if it wants, one data byte. In the read direction the block returns bytes from an internal pointer. That pointer always holds the address of the most recent access plus one. It wraps from the last location back to zero, so a sequential read can run across the whole array.

A data byte is not stored as soon as it arrives. It is committed by a self-timed write cycle that starts at the STOP closing the transfer. While that cycle runs, the block does not answer its address. A controller can therefore poll for completion by repeating address attempts until one is acknowledged. SCL and SDA are sampled on the system clock through two-stage synchronizers. The block drives SDA only by pulling it low, through an output enable.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every array byte is 0, the pointer is 0 and no write cycle is running.
- R2: Bits 7..1 of the first byte after START are compared with `DEV_ADDR`, and bit 0 selects the direction (1 = read, 0 = write). On a mismatch, SDA stays released in the ninth clock and the block ignores the bus until the next START.
- R3: A write transfer consists of the address byte, a word-address byte (its low log2(DEPTH) bits are used) and one data byte. Each of the three is acknowledged. The data byte is stored `WR_CYCLES` clocks after the STOP that ends the transfer.
- R4: For the `WR_CYCLES` clocks after that STOP, a START is ignored and the address byte gets no acknowledge. Once the cycle ends, the address is acknowledged again.
- R5: Every byte written or read moves the pointer to that byte's address plus one. A read transfer opened without a word address returns the byte at the pointer.
- R6: A write-direction word address followed by a repeated START in the read direction returns the byte at that word address. A word address followed directly by STOP loads the pointer and does not start a write cycle.
- R7: When the controller acknowledges a returned byte, the next location is sent. After location DEPTH-1 the next location is 0.
- R8: When the controller does not acknowledge a returned byte, SDA stays released and the block waits for the next START.
- R9: A repeated START after a data byte, with no STOP in between, discards that byte and starts no write cycle.
- R10: `sda_oe` rises only while SCL is low. An acknowledge holds SDA low through the ninth clock, and data bits leave MSB first.
- R11: A START or a STOP in the middle of a byte abandons that byte. The next transfer is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the block with a 16-byte array, address 0x50 and a 1500-clock write cycle. With a 16-byte array, the wrap from location 15 to 0 can be reached both by a write and within a single sequential read. A 1500-clock write cycle outlasts several complete polling attempts, so the bench sees refused addresses first and then an acknowledge, all within a short run. The bench also uses a 10-clock quarter bit so that every synchronizer delay settles well inside each SCL phase.

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         DEPTH     = 256,
  parameter int         WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RDATA} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_p, sda_p, scl_s, sda_s;
  logic start_c, stop_c, rise, fall;
  st_t state;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx, wr_data;
  logic [AW-1:0] ptr, wr_addr, ptr_inc;
  logic ackf, wr_pend, busy;
  logic [CW-1:0] busy_cnt;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign busy    = busy_cnt != '0;
  assign ptr_inc = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
  assign rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; sr <= '0; tx <= '0; ptr <= '0;
      ackf <= 1'b0; sda_oe <= 1'b0; wr_pend <= 1'b0;
      wr_addr <= '0; wr_data <= '0; busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - CW'(1);
      if (start_c) begin
        sda_oe <= 1'b0; ackf <= 1'b0; bitcnt <= '0; wr_pend <= 1'b0;
        state <= busy ? S_IDLE : S_DEV;
      end else if (stop_c) begin
        sda_oe <= 1'b0; ackf <= 1'b0; bitcnt <= '0; state <= S_IDLE;
        if (wr_pend) begin
          wr_pend  <= 1'b0;
          busy_cnt <= CW'(WR_CYCLES);
        end
      end else if (rise) begin
        if (ackf) bitcnt <= '0;
        else if (state != S_IDLE) begin
          if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (state != S_RDATA) sr <= {sr[6:0], sda_s};
          end else begin
            bitcnt <= '0;
            if (!sda_s) ackf <= 1'b1;
            else        state <= S_IDLE;
          end
        end
      end else if (fall) begin
        if (ackf && bitcnt == 4'd0) begin
          ackf <= 1'b0;
          if (state == S_RDATA) begin
            sda_oe <= ~rd_byte[7];
            tx     <= {rd_byte[6:0], 1'b0};
            ptr    <= ptr_inc;
          end else sda_oe <= 1'b0;
        end else if (!ackf && bitcnt == 4'd8) begin
          case (state)
            S_DEV:
              if (sr[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1; ackf <= 1'b1;
                state  <= sr[0] ? S_RDATA : S_WADDR;
              end else state <= S_IDLE;
            S_WADDR: begin
              sda_oe <= 1'b1; ackf <= 1'b1; ptr <= sr[AW-1:0]; state <= S_WDATA;
            end
            S_WDATA: begin
              sda_oe <= 1'b1; ackf <= 1'b1;
              wr_data <= sr; wr_addr <= ptr; ptr <= ptr_inc;
              wr_pend <= 1'b1; state <= S_IDLE;
            end
            S_RDATA: sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (state == S_RDATA && !ackf) begin
          sda_oe <= ~tx[7];
          tx     <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (busy_cnt == CW'(1)) begin
      mem[wr_addr] <= wr_data;
    end

  a_r10_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state == S_IDLE && !sda_oe));
  a_r3_stop_arms_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && wr_pend) |=> busy_cnt == CW'(WR_CYCLES));
  a_r3_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mem[wr_addr] == wr_data);
  a_r2_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !start_c && !stop_c && state == S_DEV && !ackf && bitcnt == 4'd8
     && sr[7:1] != DEV_ADDR) |=> !sda_oe);
endmodule

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;
  localparam logic [6:0] DEV = 7'h50;
  localparam int QT = 10;

  typedef struct { logic [7:0] val; string tag; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic done = 1'b0;
  int checks = 0;
  int errors = 0;
  item_t exp_q[$];
  logic [7:0] obs_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_target #(.DEV_ADDR(DEV), .DEPTH(16), .WR_CYCLES(1500)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe));

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pops observed results and compares with the scoreboard
  initial forever begin
    @(posedge clk);
    while (obs_q.size() > 0) begin
      logic [7:0] o;
      item_t e;
      o = obs_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "unexpected", o, 8'h00);
      else begin
        e = exp_q.pop_front();
        chk(o === e.val, e.tag, o, e.val);
      end
    end
  end

  // R10: the target pulls SDA only while SCL is low
  always @(posedge sda_oe) if (rst_n) chk(!m_scl, "R10", {7'd0, m_scl}, 8'h00);

  task automatic put(input logic [7:0] v, input string tag);
    exp_q.push_back('{v, tag});
  endtask

  task automatic q();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic tx_raw(input logic [7:0] d, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(a);
  endtask

  task automatic tx_byte(input logic [7:0] d);
    logic a;
    tx_raw(d, a);
    obs_q.push_back({7'd0, a});
  endtask

  task automatic rx_byte(input logic mack);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    send_bit(!mack);
    obs_q.push_back(d);
  endtask

  task automatic do_write(input logic [7:0] wa, input logic [7:0] d, input string tag);
    put(8'h00, tag); put(8'h00, tag); put(8'h00, tag);
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(wa); tx_byte(d); bus_stop();
  endtask

  task automatic poll_ready(input string tag);
    logic a;
    int n;
    a = 1'b1; n = 0;
    while (a && n < 50) begin
      bus_start(); tx_raw({DEV, 1'b0}, a); bus_stop(); n++;
    end
    chk(a == 1'b0, tag, {7'd0, a}, 8'h00);
  endtask

  task automatic wait_drain();
    while (obs_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset", {7'd0, sda_oe}, 8'h00);

    // R2: foreign address, both directions, is not acknowledged
    put(8'h01, "R2 write dir"); bus_start(); tx_byte({7'h51, 1'b0}); bus_stop();
    put(8'h01, "R2 read dir");  bus_start(); tx_byte({7'h51, 1'b1}); bus_stop();

    // R3 write, then R4 immediate poll is refused, then ready
    do_write(8'h03, 8'hA5, "R3");
    put(8'h01, "R4 busy nack"); bus_start(); tx_byte({DEV, 1'b0}); bus_stop();
    poll_ready("R4 ready");
    do_write(8'h04, 8'h3C, "R3"); poll_ready("R4");
    do_write(8'h02, 8'h5A, "R3"); poll_ready("R4");

    // R6 random read of 3, R8 release after NACK
    put(8'h00, "R6"); put(8'h00, "R6"); put(8'h00, "R6"); put(8'hA5, "R6 data");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h03);
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();
    wait_drain();
    chk(sda_oe == 1'b0, "R8 released", {7'd0, sda_oe}, 8'h00);

    // R5 current-address read follows the read of 3
    put(8'h00, "R5"); put(8'h3C, "R5 data");
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    // R7 wrap on write: last location then pointer at 0
    do_write(8'h0E, 8'h77, "R3"); poll_ready("R4");
    do_write(8'h00, 8'h22, "R3"); poll_ready("R4");
    do_write(8'h0F, 8'h11, "R3"); poll_ready("R4");
    put(8'h00, "R5"); put(8'h22, "R7 write wrap");
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    // R7 sequential read across the top of the array
    put(8'h00, "R7"); put(8'h00, "R7"); put(8'h00, "R7");
    put(8'h77, "R7 seq"); put(8'h11, "R7 seq"); put(8'h22, "R7 wrap"); put(8'h00, "R7 seq");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h0E);
    bus_start(); tx_byte({DEV, 1'b1});
    rx_byte(1'b1); rx_byte(1'b1); rx_byte(1'b1); rx_byte(1'b0); bus_stop();
    put(8'h00, "R5"); put(8'h5A, "R5 after seq");
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    // R6 word address only: no busy window, pointer loaded
    put(8'h00, "R6"); put(8'h00, "R6");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h04); bus_stop();
    put(8'h00, "R6 no busy"); put(8'h3C, "R6 ptr load");
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    // R9 repeated START after data discards it
    put(8'h00, "R9"); put(8'h00, "R9"); put(8'h00, "R9");
    put(8'h00, "R9 no busy"); put(8'h00, "R9 next loc");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h06); tx_byte(8'h99);
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();
    put(8'h00, "R9 no busy"); put(8'h00, "R9"); put(8'h00, "R9"); put(8'h00, "R9 discarded");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h06);
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    // R11 STOP mid-byte, then a clean random read
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); bus_stop();
    put(8'h00, "R11"); put(8'h00, "R11"); put(8'h00, "R11"); put(8'hA5, "R11 after stop");
    bus_start(); tx_byte({DEV, 1'b0}); tx_byte(8'h03);
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();
    // R11 START mid-byte, then a current-address read
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    put(8'h00, "R11"); put(8'h3C, "R11 after start");
    bus_start(); tx_byte({DEV, 1'b1}); rx_byte(1'b0); bus_stop();

    wait_drain();
    chk(exp_q.size() == 0, "scoreboard empty", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule